// File: doc/BRIEF.md
# Clock Output Power-Down and Gating Sequencer

This block sits between a clock generator's core and its output buffers. It decides, cycle by cycle, which output clocks may run, when the oscillator and PLL may be switched off, and when the configuration registers must be wiped. A single board pin serves two purposes. At first it reports that supply power is good. Once it has been seen high, it becomes a permanent active-low power-down request for the rest of the block's life.

Entry into power-down follows a fixed order. The asynchronous pin is synchronized and must read the same low level on two consecutive edges. Each output is then closed on a falling edge of its own clock. The shutdown request goes out only once every output is closed. On release, outputs stay closed until the PLL reports lock, and each then opens on its own falling edge. If lock does not come within a programmable number of cycles, the block parks all outputs closed until the next power-down cycle. Per-output enable bits gate each clock individually. A test-entry bit can override normal operation, either tri-stating everything or driving all outputs with a divided reference.

Top module: `clkout_pwr_ctrl`

## Requirements
- R1: After reset the pin is a power-good input. All gates stay closed and `osc_off` stays 0 until the synchronized pin reads high on two consecutive edges. After that the state never returns to the power-good phase.
- R2: The pin passes a two-flop synchronizer. A level is honored only when the synchronized value is the same on two consecutive edges, so the state reacts three edges after the pin is first sampled. A low pulse lasting a single clock cycle is ignored.
- R3: When power-down is honored, each `out_gate[i]` drops to 0 at the first edge where `out_clk[i]` is sampled 0 after being sampled 1 on the previous edge.
- R4: `osc_off` rises only on the edge after all gates have been seen 0, stays 1 while powered down, and returns to 0 when a release is honored.
- R5: After release, all gates stay 0 until `pll_locked` is 1. Each enabled gate then opens at its own next falling edge.
- R6: If `pll_locked` stays 0 for LOCK_TMO consecutive cycles of waiting, all gates are held 0 (even if lock arrives later) until a power-down is honored.
- R7: When power-down is honored with `cfg_keep`=0, `cfg_clear` is 1 for exactly one cycle. With `cfg_keep`=1 it stays 0.
- R8: `out_en[i]`=1 enables output i and 0 disables it. A change affects `out_gate[i]` only at that output's falling edge.
- R9: `test_entry`=1 with `test_sel`=0 sets `hiz`=1 and closes every gate. `test_entry`=1 with `test_sel`=1 sets `div_sel`=1 and opens every gate regardless of `out_en`. `hiz` and `div_sel` follow their inputs one edge later.
- R10: `div_clk` toggles every DIV_HALF cycles starting from 0 after reset. The reset state has all outputs at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_pin | input | 1 | Asynchronous power-good / active-low power-down pin |
| pll_locked | input | 1 | PLL lock indication |
| cfg_keep | input | 1 | 1 keeps configuration across power-down, 0 clears it |
| out_en | input | N_OUT | Per-output enable, 1 = enabled |
| test_entry | input | 1 | Test mode entry |
| test_sel | input | 1 | Test mode select: 0 tri-state, 1 divided reference |
| out_clk | input | N_OUT | Sampled level of each output clock |
| out_gate | output | N_OUT | Per-output run gate |
| hiz | output | 1 | Tri-state all outputs |
| div_sel | output | 1 | Drive outputs with the divided reference |
| div_clk | output | 1 | Divided reference clock |
| osc_off | output | 1 | PLL and oscillator shutdown request |
| cfg_clear | output | 1 | One-cycle configuration clear pulse |

## Verification
The bench builds the block with N_OUT=4, LOCK_TMO=20 and DIV_HALF=3. A 20-cycle lock timeout lets the fault path and its recovery happen many times in a short run. The four output clocks have different half-periods, so each gate closes and opens on a different edge during power-down and release. Directed phases cover the single-cycle glitch, keep versus clear, and both test modes. A random phase then mixes pin pulses of varying length with lock, enable and test changes.

// File: rtl/clkout_pwr_pkg.sv
// Package: shared sequencer state type for the clock output power controller.
// Assumes: nothing beyond IEEE 1800-2017.
package clkout_pwr_pkg;
    typedef enum logic [2:0] {
        ST_PGOOD    = 3'd0,
        ST_LOCKWAIT = 3'd1,
        ST_RUN      = 3'd2,
        ST_FAULT    = 3'd3,
        ST_STOPPING = 3'd4,
        ST_OFF      = 3'd5
    } seq_state_t;
endpackage

// File: rtl/pd_pin_sync.sv
// Module: pd_pin_sync
// Brings the asynchronous shared pin into the clk domain through SYNC_STAGES
// flops, plus one confirm flop. It reports a level only when the last two
// synchronized samples agree.
// Assumes: pin may change at any time; clk is free running.
module pd_pin_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_async,
    output logic lvl_hi,
    output logic lvl_lo
);
    localparam int SR_W = SYNC_STAGES + 1;

    logic [SR_W-1:0] sr_q;

    // Shift the pin through synchronizer and confirm stages.
    always_ff @(posedge clk) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= {sr_q[SR_W-2:0], pin_async};
    end

    assign lvl_hi = sr_q[SR_W-1] & sr_q[SR_W-2];
    assign lvl_lo = ~sr_q[SR_W-1] & ~sr_q[SR_W-2];

    // R2: a confirmed low needs two consecutive low synchronized samples
    a_r2_low_needs_two: assert property (@(posedge clk) disable iff (!rst_n)
        lvl_lo |-> $past(~sr_q[SR_W-2]));
endmodule

// File: rtl/pd_seq_fsm.sv
// Module: pd_seq_fsm
// Power sequencer: power-good phase, lock wait with timeout, run, fault park,
// stopping (waits for all gates closed) and off (shutdown request).
// Assumes: lvl_hi/lvl_lo come from pd_pin_sync; gates_idle reflects the
// registered output gates.
module pd_seq_fsm
    import clkout_pwr_pkg::*;
#(
    parameter int LOCK_TMO = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_hi,
    input  logic lvl_lo,
    input  logic pll_locked,
    input  logic gates_idle,
    input  logic cfg_keep,
    output logic run_o,
    output logic osc_off_o,
    output logic cfg_clear_o
);
    localparam int CW = $clog2(LOCK_TMO + 1);

    seq_state_t      state_q, state_d;
    logic [CW-1:0]   wait_cnt_q;
    logic            clear_q;

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_PGOOD:    if (lvl_hi) state_d = ST_LOCKWAIT;
            ST_LOCKWAIT: begin
                if (lvl_lo)                             state_d = ST_STOPPING;
                else if (pll_locked)                    state_d = ST_RUN;
                else if (wait_cnt_q == CW'(LOCK_TMO-1)) state_d = ST_FAULT;
            end
            ST_RUN,
            ST_FAULT:    if (lvl_lo) state_d = ST_STOPPING;
            ST_STOPPING: if (gates_idle) state_d = ST_OFF;
            ST_OFF:      if (lvl_hi) state_d = ST_LOCKWAIT;
            default:     state_d = ST_PGOOD;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_PGOOD;
        else        state_q <= state_d;
    end

    // Lock-wait cycle counter, cleared outside the lock-wait state.
    always_ff @(posedge clk) begin
        if (!rst_n || state_q != ST_LOCKWAIT) wait_cnt_q <= '0;
        else                                  wait_cnt_q <= wait_cnt_q + 1'b1;
    end

    // One-cycle configuration clear on power-down entry when not keeping.
    always_ff @(posedge clk) begin
        if (!rst_n) clear_q <= 1'b0;
        else        clear_q <= (state_d == ST_STOPPING) && (state_q != ST_STOPPING) && !cfg_keep;
    end

    assign run_o       = (state_q == ST_RUN);
    assign osc_off_o   = (state_q == ST_OFF);
    assign cfg_clear_o = clear_q;

    // R1: once the power-good phase is left it never returns
    a_r1_pgood_left_for_good: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) != ST_PGOOD) |-> (state_q != ST_PGOOD));
    // R5: run is entered only with lock present
    a_r5_run_needs_lock: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && $past(state_q) != ST_RUN) |-> $past(pll_locked));
    // R6: fault is entered only at the end of the lock window
    a_r6_fault_at_timeout: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FAULT && $past(state_q) == ST_LOCKWAIT) |-> ($past(wait_cnt_q) == CW'(LOCK_TMO-1)));
    // R7: the clear pulse lasts one cycle
    a_r7_clear_single: assert property (@(posedge clk) disable iff (!rst_n)
        clear_q |=> !clear_q);
endmodule

// File: rtl/out_gate_bank.sv
// Module: out_gate_bank
// One gate flop per output. A gate only moves on a sampled falling edge of its
// own output clock, so an output never produces a runt pulse.
// Assumes: out_clk levels are synchronous to clk and slower than clk/2.
module out_gate_bank #(
    parameter int N_OUT = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [N_OUT-1:0] en_mask,
    input  logic             test_entry,
    input  logic             test_sel,
    input  logic [N_OUT-1:0] out_clk,
    output logic [N_OUT-1:0] gate_o,
    output logic             idle_o
);
    logic [N_OUT-1:0] clk_d_q;
    logic [N_OUT-1:0] gate_q;

    for (genvar i = 0; i < N_OUT; i++) begin : g_lane
        logic fall;
        logic want;
        assign fall = clk_d_q[i] & ~out_clk[i];
        assign want = run & (test_entry ? test_sel : en_mask[i]);

        // Remember the previous clock level for falling-edge detection.
        always_ff @(posedge clk) begin
            if (!rst_n) clk_d_q[i] <= 1'b0;
            else        clk_d_q[i] <= out_clk[i];
        end

        // Update the gate only on this output's falling edge.
        always_ff @(posedge clk) begin
            if (!rst_n)    gate_q[i] <= 1'b0;
            else if (fall) gate_q[i] <= want;
        end

        // R3, R8: a gate changes only right after a sampled falling edge
        a_r3_gate_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
            (gate_q[i] != $past(gate_q[i])) |-> ($past(clk_d_q[i]) && !$past(out_clk[i])));
    end

    assign gate_o = gate_q;
    assign idle_o = ~|gate_q;
endmodule

// File: rtl/ref_divider.sv
// Module: ref_divider
// Divides clk by 2*DIV_HALF to make the test-mode reference.
// Assumes: DIV_HALF >= 1.
module ref_divider #(
    parameter int DIV_HALF = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic div_o
);
    localparam int DW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;

    logic [DW-1:0] cnt_q;
    logic          div_q;

    // Count DIV_HALF cycles, then toggle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            div_q <= 1'b0;
        end else if (cnt_q == DW'(DIV_HALF-1)) begin
            cnt_q <= '0;
            div_q <= ~div_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign div_o = div_q;

    // R10: the divided clock never holds longer than DIV_HALF cycles
    a_r10_div_toggles: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '0 && $past(rst_n) && $past(cnt_q) == DW'(DIV_HALF-1)) |-> (div_q != $past(div_q)));
endmodule

// File: rtl/clkout_pwr_ctrl.sv
// Module: clkout_pwr_ctrl (top)
// Sequences clock outputs into and out of power-down, gates each output from
// its enable and the test bits, requests oscillator shutdown only after every
// output is closed, and pulses configuration clear on power-down entry.
// Assumes: clk is the reference clock; out_clk are the output clock levels.
module clkout_pwr_ctrl #(
    parameter int N_OUT    = 5,
    parameter int LOCK_TMO = 1000,
    parameter int DIV_HALF = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_pin,
    input  logic             pll_locked,
    input  logic             cfg_keep,
    input  logic [N_OUT-1:0] out_en,
    input  logic             test_entry,
    input  logic             test_sel,
    input  logic [N_OUT-1:0] out_clk,
    output logic [N_OUT-1:0] out_gate,
    output logic             hiz,
    output logic             div_sel,
    output logic             div_clk,
    output logic             osc_off,
    output logic             cfg_clear
);
    logic lvl_hi, lvl_lo;
    logic run, gates_idle;
    logic hiz_q, div_sel_q;

    pd_pin_sync #(.SYNC_STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_async(pwr_pin),
        .lvl_hi(lvl_hi), .lvl_lo(lvl_lo)
    );

    pd_seq_fsm #(.LOCK_TMO(LOCK_TMO)) u_seq (
        .clk(clk), .rst_n(rst_n), .lvl_hi(lvl_hi), .lvl_lo(lvl_lo),
        .pll_locked(pll_locked), .gates_idle(gates_idle), .cfg_keep(cfg_keep),
        .run_o(run), .osc_off_o(osc_off), .cfg_clear_o(cfg_clear)
    );

    out_gate_bank #(.N_OUT(N_OUT)) u_gates (
        .clk(clk), .rst_n(rst_n), .run(run), .en_mask(out_en),
        .test_entry(test_entry), .test_sel(test_sel), .out_clk(out_clk),
        .gate_o(out_gate), .idle_o(gates_idle)
    );

    ref_divider #(.DIV_HALF(DIV_HALF)) u_div (
        .clk(clk), .rst_n(rst_n), .div_o(div_clk)
    );

    // Register the test-mode output controls.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hiz_q     <= 1'b0;
            div_sel_q <= 1'b0;
        end else begin
            hiz_q     <= test_entry & ~test_sel;
            div_sel_q <= test_entry & test_sel;
        end
    end

    assign hiz     = hiz_q;
    assign div_sel = div_sel_q;

    // R4: shutdown is requested only while every output is closed
    a_r4_osc_only_closed: assert property (@(posedge clk) disable iff (!rst_n)
        osc_off |-> (out_gate == '0));
    // R4: shutdown rises only after the gates were already closed
    a_r4_osc_after_close: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(osc_off) |-> ($past(out_gate) == '0));
    // R9: test controls follow the test inputs one edge later
    a_r9_hiz_follows: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (hiz == ($past(test_entry) && !$past(test_sel))));
endmodule

// File: tb/clkout_pwr_ctrl_tb_top.sv
module clkout_pwr_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int N        = 4;
    localparam int TMO      = 20;
    localparam int DHALF    = 3;

    localparam int M_PG = 0, M_LW = 1, M_RUN = 2, M_FLT = 3, M_STP = 4, M_OFF = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwr_pin = 1'b0, pll_locked = 1'b0, cfg_keep = 1'b0;
    logic [N-1:0] out_en = '1;
    logic test_entry = 1'b0, test_sel = 1'b0;
    logic [N-1:0] out_clk = '0;
    logic [N-1:0] out_gate;
    logic hiz, div_sel, div_clk, osc_off, cfg_clear;

    int n_cmp = 0, n_bad = 0, cyc = 0, clr_seen = 0;
    bit started = 0, done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    clkout_pwr_ctrl #(.N_OUT(N), .LOCK_TMO(TMO), .DIV_HALF(DHALF)) dut_i (
        .clk(clk), .rst_n(rst_n), .pwr_pin(pwr_pin), .pll_locked(pll_locked),
        .cfg_keep(cfg_keep), .out_en(out_en), .test_entry(test_entry),
        .test_sel(test_sel), .out_clk(out_clk), .out_gate(out_gate), .hiz(hiz),
        .div_sel(div_sel), .div_clk(div_clk), .osc_off(osc_off), .cfg_clear(cfg_clear)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // Output clocks: lane i toggles every i+2 reference cycles.
    int ocnt[N];
    always @(negedge clk) begin
        for (int i = 0; i < N; i++) begin
            ocnt[i]++;
            if (ocnt[i] >= i + 2) begin
                ocnt[i] = 0;
                out_clk[i] <= ~out_clk[i];
            end
        end
    end

    // Behavioural reference model, advanced on each rising edge.
    bit pin_hist[$];
    int m_st, m_wait, m_dc;
    bit [N-1:0] m_gate, m_prev;
    bit m_clr, m_hiz, m_dsel, m_div;
    always @(posedge clk) begin
        bit lo, hi, idle, was_run;
        int nst;
        started = 1;
        if (!rst_n) begin
            pin_hist = '{0, 0, 0, 0};
            m_st = M_PG; m_wait = 0; m_dc = 0;
            m_gate = '0; m_prev = '0;
            m_clr = 0; m_hiz = 0; m_dsel = 0; m_div = 0;
        end else begin
            pin_hist.push_front(pwr_pin);
            while (pin_hist.size() > 4) void'(pin_hist.pop_back());
            lo = !pin_hist[2] && !pin_hist[3];
            hi = pin_hist[2] && pin_hist[3];
            idle = (m_gate == '0);
            was_run = (m_st == M_RUN);
            for (int i = 0; i < N; i++) begin
                if (m_prev[i] && !out_clk[i])
                    m_gate[i] = was_run && (test_entry ? test_sel : out_en[i]);
                m_prev[i] = out_clk[i];
            end
            nst = m_st;
            case (m_st)
                M_PG:  if (hi) nst = M_LW;
                M_LW:  if (lo) nst = M_STP;
                       else if (pll_locked) nst = M_RUN;
                       else if (m_wait == TMO - 1) nst = M_FLT;
                M_RUN, M_FLT: if (lo) nst = M_STP;
                M_STP: if (idle) nst = M_OFF;
                M_OFF: if (hi) nst = M_LW;
                default: nst = M_PG;
            endcase
            m_clr = (nst == M_STP) && (m_st != M_STP) && !cfg_keep;
            m_wait = (m_st == M_LW) ? m_wait + 1 : 0;
            m_st = nst;
            m_hiz = test_entry && !test_sel;
            m_dsel = test_entry && test_sel;
            if (m_dc == DHALF - 1) begin m_dc = 0; m_div = !m_div; end
            else m_dc++;
        end
    end

    // Compare every output against the model on each falling edge.
    always @(negedge clk) begin
        if (started && !done) begin
            chk(out_gate == m_gate, "out_gate R3 R5 R8 R9", out_gate, m_gate);
            chk(osc_off == (m_st == M_OFF), "osc_off R1 R4", osc_off, m_st == M_OFF);
            chk(cfg_clear == m_clr, "cfg_clear R7", cfg_clear, m_clr);
            chk(hiz == m_hiz, "hiz R9", hiz, m_hiz);
            chk(div_sel == m_dsel, "div_sel R9", div_sel, m_dsel);
            chk(div_clk == m_div, "div_clk R10", div_clk, m_div);
            if (rst_n && cfg_clear) clr_seen++;
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        wait_cyc(3);
        rst_n = 1'b1;
        // R10: reset state
        chk(out_gate == '0 && !osc_off && !hiz && !div_sel && !cfg_clear && !div_clk,
            "R10 reset state", {out_gate, osc_off, hiz, div_sel, cfg_clear, div_clk}, 0);
        wait_cyc(10);
        // R1: power-good phase keeps gates closed and oscillator on
        chk(out_gate == '0 && !osc_off, "R1 power-good phase", {out_gate, osc_off}, 0);
        pwr_pin = 1'b1;
        wait_cyc(3 + TMO + 5);
        // R6: lock timeout parks outputs; late lock does not reopen them
        pll_locked = 1'b1;
        wait_cyc(15);
        chk(out_gate == '0, "R6 fault park", out_gate, 0);
        pwr_pin = 1'b0;
        wait_cyc(30);
        chk(osc_off == 1'b1, "R4 powered down", osc_off, 1);
        chk(clr_seen == 1, "R7 clear pulse count keep=0", clr_seen, 1);
        pll_locked = 1'b0;
        pwr_pin = 1'b1;
        wait_cyc(8);
        chk(out_gate == '0 && !osc_off, "R5 closed before lock", {out_gate, osc_off}, 0);
        pll_locked = 1'b1;
        wait_cyc(20);
        chk(out_gate == 4'hF, "R5 open after lock", out_gate, 4'hF);
        // R2: a single-cycle low pulse is ignored
        pwr_pin = 1'b0;
        wait_cyc(1);
        pwr_pin = 1'b1;
        wait_cyc(20);
        chk(out_gate == 4'hF && !osc_off, "R2 glitch ignored", {out_gate, osc_off}, {4'hF, 1'b0});
        chk(clr_seen == 1, "R2 glitch no clear", clr_seen, 1);
        out_en = 4'b1010;
        wait_cyc(20);
        chk(out_gate == 4'b1010, "R8 enable mask", out_gate, 4'b1010);
        test_entry = 1'b1; test_sel = 1'b0;
        wait_cyc(20);
        chk(hiz == 1'b1 && out_gate == '0, "R9 tri-state mode", {hiz, out_gate}, {1'b1, 4'h0});
        test_sel = 1'b1;
        wait_cyc(20);
        chk(div_sel == 1'b1 && out_gate == 4'hF, "R9 divided mode", {div_sel, out_gate}, {1'b1, 4'hF});
        test_entry = 1'b0; test_sel = 1'b0; out_en = '1;
        wait_cyc(20);
        cfg_keep = 1'b1;
        pwr_pin = 1'b0;
        wait_cyc(40);
        chk(osc_off == 1'b1 && out_gate == '0, "R4 off after stop", {osc_off, out_gate}, {1'b1, 4'h0});
        chk(clr_seen == 1, "R7 no clear with keep=1", clr_seen, 1);
        pwr_pin = 1'b1;
        wait_cyc(25);
        // Random phase, checked by the model on every cycle.
        for (int k = 0; k < 400; k++) begin
            pwr_pin    = ($urandom_range(0, 3) != 0);
            pll_locked = ($urandom_range(0, 4) != 0);
            cfg_keep   = $urandom_range(0, 1);
            out_en     = N'($urandom_range(0, 15));
            test_entry = ($urandom_range(0, 5) == 0);
            test_sel   = $urandom_range(0, 1);
            wait_cyc($urandom_range(1, 12));
        end
        wait_cyc(5);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule